// File: doc/BRIEF.md
# Table Access Mailbox Responder

This block answers table-read requests that arrive, one dword at a time, on a data-object mailbox stream. It holds a fixed, built-in attribute table of six entries that describes a single memory range. When a complete request has been received, the responder checks the declared object length. It then does one of three things: drops the request, flags a bad handle, or streams back a response. A response is a three-dword header followed by the requested entry's payload dwords.

The table always runs in the same order. First comes the range entry, which describes the memory span. Next are four latency/bandwidth entries, in this order: read latency, write latency, read bandwidth, write bandwidth. Last is a memory-type entry. Each response tells the reader which handle to ask for next, so software can walk the whole table from handle 0 until it sees the end-of-table marker. While a request is being judged or its response is still draining, the block refuses new request dwords.

Top module: `tam_responder`

## Requirements
- R1: After reset, `rsp_valid`, `busy` and `err` are low and `req_ready` is high.
- R2: A request is dropped without any response and without `err` in either of two cases: fewer than three dwords arrive before `req_last`, or the object length field (bits 17:0 of the second request dword) is less than 3. After a drop, `req_ready` returns high.
- R3: Response dword 0 carries the vendor ID 0x1E98 in bits 15:0, object type 0x02 in bits 23:16 and zero in bits 31:24.
- R4: Response dword 1 holds, in bits 17:0, the response length in dwords: header bytes (12) plus payload bytes (24), divided by 4 and rounded up, which gives 9. Its upper bits are zero. Exactly that many dwords are sent, and `rsp_last` is high on the final one only.
- R5: Response dword 2 has response code 0 in bits 7:0, table type 0 in bits 15:8 and the next handle in bits 31:16. The next handle is the requested handle plus one.
- R6: For handle 5 (the last entry), the next handle is the end-of-table marker 0xFFFF.
- R7: A request with a handle above 5 produces no response. Instead, `err` goes high for exactly one cycle.
- R8: Handle 0 returns the range entry as six payload dwords placed directly after the header. They are: {length 24 in bits 31:16, type 0 in bits 7:0}; flags 0x04 (non-volatile) in bits 15:8; base 0 (64 bits); length equal to `MEM_BYTES` (64 bits, low dword first).
- R9: Handles 1–4 return latency/bandwidth entries, each laid out as follows. Dword 0 is {24 in bits 31:16, type 1 in bits 7:0}. Dword 1 holds the data type in bits 23:16, with values 1, 2, 4 and 5 in handle order. Next comes a 64-bit base unit: 10000 for handles 1 and 2, 1000 for handles 3 and 4. It is followed by a value in bits 15:0 of the next dword: 15, 25, 16 and 16 in handle order. The last dword is zero.
- R10: Handle 5 returns the memory-type entry. Its type is 2, its attribute value is 2 in bits 15:8 of dword 1, its offset is 0 (64 bits) and its length equals `MEM_BYTES`.
- R11: `busy` is high and `req_ready` is low from the cycle after the last request dword until the last response dword is accepted. While `rsp_ready` is low, `rsp_data` and `rsp_last` hold steady.
- R12: The requested handle is taken from bits 31:16 of the third request dword, regardless of its lower bits. Any dwords after the third are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request dword valid |
| req_ready | output | 1 | Request dword accepted when high with req_valid |
| req_data | input | 32 | Request dword |
| req_last | input | 1 | Final dword of the request object |
| rsp_valid | output | 1 | Response dword valid |
| rsp_ready | input | 1 | Downstream accepts response dword |
| rsp_data | output | 32 | Response dword |
| rsp_last | output | 1 | Final dword of the response object |
| busy | output | 1 | Request being judged or response draining |
| err | output | 1 | One-cycle pulse on an out-of-range handle |

## Verification
The bench requests every valid handle under three consumer patterns: always ready, alternate cycles, and one cycle in three. This separates payload-content faults from faults in indexing or holding under backpressure. Out-of-range handles 6, 7 and 0xFFFF show the error path apart from the silent drop path. Requests that are too short, either in the length field or in actual dword count, exercise the drop itself. A five-dword request, whose extra dwords have all bits set and whose third dword has nonzero lower bits, proves that the handle is taken only from the upper half of the third dword.

// File: rtl/tam_responder.sv
module tam_responder #(
  parameter logic [63:0] MEM_BYTES = 64'h0000_0000_4000_0000,
  parameter logic [15:0] VENDOR    = 16'h1E98
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_data,
  input  logic        req_last,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  output logic        rsp_last,
  output logic        busy,
  output logic        err
);
  localparam int HDR_BYTES = 12;
  localparam int ENT_BYTES = 24;
  localparam int REQ_MIN   = (HDR_BYTES + 3) / 4;
  localparam int HDR_DW    = (HDR_BYTES + 3) / 4;
  localparam int RSP_DW    = (HDR_BYTES + ENT_BYTES + 3) / 4;
  localparam int NUM_ENT   = 6;
  localparam int LAST_ENT  = NUM_ENT - 1;
  localparam int IW        = $clog2(RSP_DW);

  logic [1:0]    rx_cnt;
  logic [17:0]   rx_len;
  logic [15:0]   rx_hdl;
  logic          eval_q, send_q, err_q;
  logic [IW-1:0] tx_idx;
  logic [2:0]    ent_q;

  wire accept = req_valid && req_ready;
  wire fire   = send_q && rsp_ready;
  wire at_end = tx_idx == IW'(RSP_DW - 1);

  assign busy      = eval_q || send_q;
  assign req_ready = !busy;
  assign rsp_valid = send_q;
  assign rsp_last  = send_q && at_end;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt <= '0;
      rx_len <= '0;
      rx_hdl <= '0;
      eval_q <= 1'b0;
      send_q <= 1'b0;
      err_q  <= 1'b0;
      tx_idx <= '0;
      ent_q  <= '0;
    end else begin
      err_q <= 1'b0;
      if (accept) begin
        if (rx_cnt == 2'd1) rx_len <= req_data[17:0];
        if (rx_cnt == 2'd2) rx_hdl <= req_data[31:16];
        if (rx_cnt != 2'd3) rx_cnt <= rx_cnt + 2'd1;
        if (req_last) eval_q <= 1'b1;
      end
      if (eval_q) begin
        eval_q <= 1'b0;
        rx_cnt <= '0;
        if (rx_cnt == 2'd3 && rx_len >= 18'(REQ_MIN)) begin
          if (rx_hdl > 16'(LAST_ENT)) err_q <= 1'b1;
          else begin
            send_q <= 1'b1;
            tx_idx <= '0;
            ent_q  <= rx_hdl[2:0];
          end
        end
      end
      if (fire) begin
        if (at_end) send_q <= 1'b0;
        else        tx_idx <= tx_idx + 1'b1;
      end
    end
  end

  logic [15:0] next_hdl;
  assign next_hdl = (ent_q == 3'(LAST_ENT)) ? 16'hFFFF : {13'd0, ent_q + 3'd1};

  logic [7:0]  etype, lbtype;
  logic [63:0] unit;
  logic [15:0] lbval;
  logic [31:0] pay;
  logic [2:0]  pk;
  logic        mid;

  assign pk  = 3'(tx_idx - IW'(HDR_DW));
  assign mid = ent_q != 3'd0 && ent_q != 3'(LAST_ENT);

  always_comb begin
    etype = (ent_q == 3'd0) ? 8'd0 : (ent_q == 3'(LAST_ENT)) ? 8'd2 : 8'd1;
    case (ent_q)
      3'd1:    begin lbtype = 8'd1; unit = 64'd10000; lbval = 16'd15; end
      3'd2:    begin lbtype = 8'd2; unit = 64'd10000; lbval = 16'd25; end
      3'd3:    begin lbtype = 8'd4; unit = 64'd1000;  lbval = 16'd16; end
      3'd4:    begin lbtype = 8'd5; unit = 64'd1000;  lbval = 16'd16; end
      default: begin lbtype = 8'd0; unit = 64'd0;     lbval = 16'd0;  end
    endcase
    case (pk)
      3'd0:    pay = {16'(ENT_BYTES), 8'h00, etype};
      3'd1:    pay = (ent_q == 3'd0) ? 32'h0000_0400 :
                     (ent_q == 3'(LAST_ENT)) ? 32'h0000_0200 : {8'h00, lbtype, 16'h0000};
      3'd2:    pay = mid ? unit[31:0]  : 32'd0;
      3'd3:    pay = mid ? unit[63:32] : 32'd0;
      3'd4:    pay = mid ? {16'h0000, lbval} : MEM_BYTES[31:0];
      3'd5:    pay = mid ? 32'd0 : MEM_BYTES[63:32];
      default: pay = 32'd0;
    endcase
    case (tx_idx)
      IW'(0):  rsp_data = {8'h00, 8'h02, VENDOR};
      IW'(1):  rsp_data = {14'd0, 18'(RSP_DW)};
      IW'(2):  rsp_data = {next_hdl, 16'h0000};
      default: rsp_data = pay;
    endcase
  end
endmodule

// File: rtl/tam_responder_chk.sv
module tam_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        rsp_last,
  input logic        busy,
  input logic        err
);
  logic [4:0] beats;
  always_ff @(posedge clk) begin
    if (!rst_n) beats <= '0;
    else if (rsp_valid && rsp_ready) beats <= rsp_last ? 5'd0 : beats + 5'd1;
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_last));
  a_r11_block: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready && busy);
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  a_r7_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rsp_valid);
  a_r4_count: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_last |-> beats == 5'd8);
  a_r4_end: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_last |=> !rsp_valid);
endmodule

bind tam_responder tam_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
  .busy(busy), .err(err)
);

// File: tb/tb_tam_responder.sv
module tb_tam_responder;
  localparam int CLK_NS = 10;
  localparam logic [63:0] MEMSZ = 64'h0000_0000_4000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_last = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_data = '0;
  logic req_ready, rsp_valid, rsp_last, busy, err;
  logic [31:0] rsp_data;
  int n_chk = 0, n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  tam_responder #(.MEM_BYTES(MEMSZ)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_last(req_last), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .busy(busy), .err(err));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_dw(input int h, input int k);
    logic [31:0] u;
    int v;
    u = (h == 1 || h == 2) ? 32'd10000 : 32'd1000;
    v = (h == 1) ? 15 : (h == 2) ? 25 : 16;
    case (k)
      0: return 32'h0002_1E98;
      1: return 32'd9;
      2: return {(h == 5) ? 16'hFFFF : 16'(h + 1), 16'h0000};
      3: return {16'd24, 8'h00, (h == 0) ? 8'd0 : (h == 5) ? 8'd2 : 8'd1};
      4: return (h == 0) ? 32'h400 : (h == 5) ? 32'h200 :
                {8'h00, (h <= 2) ? 8'(h) : 8'(h + 1), 16'h0000};
      5: return (h == 0 || h == 5) ? 32'd0 : u;
      6: return 32'd0;
      7: return (h == 0 || h == 5) ? MEMSZ[31:0] : 32'(v);
      default: return (h == 0 || h == 5) ? MEMSZ[63:32] : 32'd0;
    endcase
  endfunction

  task automatic send_req(input logic [17:0] len, input logic [15:0] hdl, input int nbeats);
    for (int b = 0; b < nbeats; b++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_last  = (b == nbeats - 1);
      case (b)
        0: req_data = 32'h0002_1E98;
        1: req_data = {14'd0, len};
        2: req_data = {hdl, 16'h00A5};
        default: req_data = 32'hFFFF_FFFF;
      endcase
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    req_last  = 1'b0;
  endtask

  task automatic collect(input int h, input int pat, input string tag);
    int k = 0, cyc = 0;
    while (k < 9 && cyc < 100) begin
      @(negedge clk);
      rsp_ready = (pat == 0) ? 1'b1 : (pat == 1) ? cyc[0] : (cyc % 3 == 2);
      #1;
      if (rsp_valid) chk(!req_ready && busy, "R11 blocked while sending", {30'd0, req_ready, busy}, 32'd1);
      if (rsp_valid && rsp_ready) begin
        chk(rsp_data === exp_dw(h, k), tag, rsp_data, exp_dw(h, k));
        chk(rsp_last === (k == 8), "R4 last flag", {31'd0, rsp_last}, {31'd0, k == 8});
        k++;
      end
      cyc++;
    end
    chk(k == 9, "R4 dword count", k, 9);
    @(negedge clk);
    rsp_ready = 1'b0;
    #1;
    chk(!rsp_valid && req_ready && !busy, "R11 released", {30'd0, rsp_valid, busy}, 32'd0);
  endtask

  task automatic watch(input bit want_err, input string tag);
    int nv = 0, ne = 0;
    rsp_ready = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); #1;
      if (rsp_valid) nv++;
      if (err) ne++;
    end
    rsp_ready = 1'b0;
    chk(nv == 0, {tag, " no response"}, nv, 0);
    chk(ne == (want_err ? 1 : 0), {tag, " err pulses"}, ne, want_err ? 1 : 0);
    chk(req_ready === 1'b1, {tag, " ready back"}, {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (CLK_NS * 20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(!rsp_valid && !busy && !err && req_ready, "R1 reset state",
        {28'd0, rsp_valid, busy, err, req_ready}, 32'd1);

    for (int pat = 0; pat < 3; pat++)
      for (int h = 0; h < 6; h++) begin
        send_req(18'd3, 16'(h), 3);
        case (h)
          0: collect(h, pat, "R8 R3 R5 range entry");
          5: collect(h, pat, "R10 R6 type entry");
          default: collect(h, pat, "R9 R5 lat/bw entry");
        endcase
      end

    send_req(18'd3, 16'd6, 3);      watch(1'b1, "R7 handle 6");
    send_req(18'd3, 16'd7, 3);      watch(1'b1, "R7 handle 7");
    send_req(18'd4, 16'hFFFF, 3);   watch(1'b1, "R7 handle FFFF");
    send_req(18'd2, 16'd1, 3);      watch(1'b0, "R2 length 2");
    send_req(18'd0, 16'd0, 3);      watch(1'b0, "R2 length 0");
    send_req(18'd3, 16'd0, 2);      watch(1'b0, "R2 two dwords");
    send_req(18'd3, 16'd0, 1);      watch(1'b0, "R2 one dword");

    send_req(18'd5, 16'd2, 5);
    collect(2, 1, "R12 extra dwords ignored");
    send_req(18'h3FFFF, 16'd4, 4);
    collect(4, 2, "R12 large length accepted");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule